// File: doc/BRIEF.md
# Inner Label Classifier

This block parses the inner header of an encapsulated data packet. The packet arrives one byte per beat on a valid/ready stream input whose first byte is the first byte of the inner destination MAC address. The parser steps over the destination and source MAC addresses and then reads the label area that follows. It works out whether the packet carries a 12-bit VLAN label or a 24-bit fine-grained label split into two tagged halves. Anything else is reported as an unknown or a malformed packet.

Each packet produces one result, held for one cycle and marked by a valid strobe. The result holds a class code, a discard flag, the label, the transport priority and drop-eligible bit, and the original priority and drop-eligible bit that a later egress stage restores. Bytes after the deciding byte are consumed and have no effect. The parser returns to its start state on the last beat of each packet.

Top module: `inner_label_parser`

## Requirements
- R1: While reset is asserted, `s_tready_o` and `res_valid_o` are low. `s_tready_o` is high from the first cycle after reset is released, and a byte is consumed only on a cycle with both valid and ready high.
- R2: The first 12 bytes of a packet (both MAC addresses) are skipped, whatever they contain. The label-area Ethertype is bytes 12 and 13, and the first of these is the upper byte.
- R3: Ethertype 0x8100 gives class 1 (VLAN) with discard low. The next 16-bit word, bytes 14 and 15, holds the priority in bits 15:13, the drop-eligible bit in bit 12 and the VLAN ID in bits 11:0. The label output is the VLAN ID zero-extended to 24 bits. The transport and the original priority/DEI both equal the word's fields.
- R4: Ethertype 0x893B gives a fine-grained packet: a high word (bytes 14-15), a second Ethertype (bytes 16-17) and a low word (bytes 18-19), each word laid out as in R3. The result is class 2 with discard low, and the label is {high[11:0], low[11:0]}.
- R5: For a fine-grained packet the transport priority/DEI come from the high word and the original priority/DEI come from the low word.
- R6: In a fine-grained packet, a second Ethertype other than 0x893B gives class 3 with discard high. The decision is made on byte 17.
- R7: Any first Ethertype other than 0x8100 or 0x893B gives class 0 with discard high. The decision is made on byte 13.
- R8: A packet whose last beat comes before its deciding byte (15 for VLAN, 19 for fine-grained, or earlier) gives class 3 with discard high, decided on that last beat.
- R9: Exactly one result is given per packet. It appears on the cycle after the clock edge that consumed the deciding byte. Bytes after the deciding byte do not change it.
- R10: Cycles with valid low consume nothing and do not change the result. After the last beat, the next byte is treated as byte 0 of a new packet.
- R11: Whenever discard is high in a result, the label, priority and DEI outputs are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| s_tdata_i | input | 8 | Packet byte |
| s_tvalid_i | input | 1 | Byte valid |
| s_tlast_i | input | 1 | Last byte of packet |
| s_tready_o | output | 1 | Parser can take a byte |
| res_valid_o | output | 1 | One-cycle strobe: result fields valid |
| res_class_o | output | 2 | 0 unknown, 1 VLAN, 2 fine-grained, 3 malformed |
| res_discard_o | output | 1 | Packet must be dropped |
| res_label_o | output | 24 | Label (VLAN ID zero-extended or 24-bit label) |
| res_tx_pcp_o | output | 3 | Transport priority |
| res_tx_dei_o | output | 1 | Transport drop-eligible bit |
| res_org_pcp_o | output | 3 | Original priority to restore |
| res_org_dei_o | output | 1 | Original drop-eligible bit to restore |

## Verification
The hardest cases to reach from the ports are a packet that ends on exactly the byte that would have completed a decision, and a packet that ends one byte short of it. Only those two cases separate "decide on the last beat" from "malformed on the last beat". The vector table sets the packet length per entry so that the final beat falls on byte 13, 15, 18 or 19. The MAC bytes are filled with a repeating 0x81/0x00 pattern so that a parser reading too early would see a VLAN tag. The whole table is then replayed with idle cycles between bytes, so that stalls and back-to-back packet starts are covered.

// File: rtl/lbl_pkg.sv
package lbl_pkg;

  localparam logic [15:0] ETYPE_VLAN = 16'h8100;
  localparam logic [15:0] ETYPE_FINE = 16'h893B;

  typedef enum logic [1:0] {
    CLS_UNKNOWN = 2'd0,
    CLS_VLAN    = 2'd1,
    CLS_FINE    = 2'd2,
    CLS_BAD     = 2'd3
  } lbl_class_e;

  typedef struct packed {
    logic [2:0]  pcp;
    logic        dei;
    logic [11:0] id;
  } tag_word_t;

  typedef struct packed {
    lbl_class_e  cls;
    logic        discard;
    logic [23:0] label;
    logic [2:0]  tx_pcp;
    logic        tx_dei;
    logic [2:0]  org_pcp;
    logic        org_dei;
  } lbl_result_t;

endpackage

// File: rtl/lbl_beat_ctr.sv
module lbl_beat_ctr #(
  parameter int MAX_POS = 20,
  parameter int CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic             last_i,
  input  logic             decide_i,
  output logic [CNT_W-1:0] pos_o,
  output logic             done_o
);

  logic [CNT_W-1:0] pos_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      done_q <= 1'b0;
    end else if (beat_i) begin
      if (last_i) begin
        pos_q  <= '0;
        done_q <= 1'b0;
      end else begin
        // saturate: bytes past the label area carry no meaning
        if (pos_q < CNT_W'(MAX_POS)) pos_q <= pos_q + 1'b1;
        if (decide_i) done_q <= 1'b1;
      end
    end
  end

  assign pos_o  = pos_q;
  assign done_o = done_q;

  a_r9_single_decision: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !decide_i);

  a_r10_restart_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_i && last_i) |=> (pos_o == '0 && !done_o));

  a_r9_pos_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= CNT_W'(MAX_POS));

endmodule

// File: rtl/lbl_field_cap.sv
module lbl_field_cap
  import lbl_pkg::*;
#(
  parameter int ET1_END = 13,
  parameter int W1_END  = 15,
  parameter int CNT_W   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             beat_i,
  input  logic [7:0]       data_i,
  input  logic [CNT_W-1:0] pos_i,
  output logic [15:0]      word_o,
  output tag_word_t        w1_o,
  output logic             fine_o
);

  logic [7:0] prev_q;
  tag_word_t  w1_q;
  logic       fine_q;

  assign word_o = {prev_q, data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      w1_q   <= '0;
      fine_q <= 1'b0;
    end else if (beat_i) begin
      prev_q <= data_i;
      if (pos_i == CNT_W'(ET1_END)) fine_q <= (word_o == ETYPE_FINE);
      if (pos_i == CNT_W'(W1_END))  w1_q   <= tag_word_t'(word_o);
    end
  end

  assign w1_o   = w1_q;
  assign fine_o = fine_q;

endmodule

// File: rtl/lbl_decide.sv
module lbl_decide
  import lbl_pkg::*;
#(
  parameter int ET1_END = 13,
  parameter int W1_END  = 15,
  parameter int ET2_END = 17,
  parameter int W2_END  = 19,
  parameter int CNT_W   = 5
) (
  input  logic             beat_i,
  input  logic             last_i,
  input  logic             done_i,
  input  logic [CNT_W-1:0] pos_i,
  input  logic [15:0]      word_i,
  input  tag_word_t        w1_i,
  input  logic             fine_i,
  output logic             decide_o,
  output lbl_result_t      res_o
);

  tag_word_t cur;
  assign cur = tag_word_t'(word_i);

  always_comb begin
    decide_o = 1'b0;
    res_o    = '0;
    if (beat_i && !done_i) begin
      if (pos_i == CNT_W'(ET1_END)) begin
        if (word_i != ETYPE_VLAN && word_i != ETYPE_FINE) begin
          decide_o      = 1'b1;
          res_o.cls     = CLS_UNKNOWN;
          res_o.discard = 1'b1;
        end
      end else if (pos_i == CNT_W'(W1_END)) begin
        if (!fine_i) begin
          decide_o      = 1'b1;
          res_o.cls     = CLS_VLAN;
          res_o.label   = {12'h000, cur.id};
          res_o.tx_pcp  = cur.pcp;
          res_o.tx_dei  = cur.dei;
          res_o.org_pcp = cur.pcp;
          res_o.org_dei = cur.dei;
        end
      end else if (pos_i == CNT_W'(ET2_END)) begin
        if (fine_i && word_i != ETYPE_FINE) begin
          decide_o      = 1'b1;
          res_o.cls     = CLS_BAD;
          res_o.discard = 1'b1;
        end
      end else if (pos_i == CNT_W'(W2_END)) begin
        if (fine_i) begin
          decide_o      = 1'b1;
          res_o.cls     = CLS_FINE;
          res_o.label   = {w1_i.id, cur.id};
          res_o.tx_pcp  = w1_i.pcp;
          res_o.tx_dei  = w1_i.dei;
          res_o.org_pcp = cur.pcp;
          res_o.org_dei = cur.dei;
        end
      end
      // truncated before any decision
      if (!decide_o && last_i) begin
        decide_o      = 1'b1;
        res_o         = '0;
        res_o.cls     = CLS_BAD;
        res_o.discard = 1'b1;
      end
    end
  end

endmodule

// File: rtl/inner_label_parser.sv
module inner_label_parser
  import lbl_pkg::*;
#(
  parameter int MAC_BYTES = 12
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  s_tdata_i,
  input  logic        s_tvalid_i,
  input  logic        s_tlast_i,
  output logic        s_tready_o,
  output logic        res_valid_o,
  output logic [1:0]  res_class_o,
  output logic        res_discard_o,
  output logic [23:0] res_label_o,
  output logic [2:0]  res_tx_pcp_o,
  output logic        res_tx_dei_o,
  output logic [2:0]  res_org_pcp_o,
  output logic        res_org_dei_o
);

  localparam int ET1_END = MAC_BYTES + 1;
  localparam int W1_END  = MAC_BYTES + 3;
  localparam int ET2_END = MAC_BYTES + 5;
  localparam int W2_END  = MAC_BYTES + 7;
  localparam int MAX_POS = W2_END + 1;
  localparam int CNT_W   = $clog2(MAX_POS + 1);

  logic             ready_q;
  logic             beat;
  logic [CNT_W-1:0] pos;
  logic             done;
  logic [15:0]      word;
  tag_word_t        w1;
  logic             fine;
  logic             decide;
  lbl_result_t      res_d, res_q;
  logic             vld_q;

  assign beat = s_tvalid_i && ready_q;

  lbl_beat_ctr #(.MAX_POS(MAX_POS), .CNT_W(CNT_W)) u_ctr (
    .clk_i, .rst_ni,
    .beat_i  (beat),
    .last_i  (s_tlast_i),
    .decide_i(decide),
    .pos_o   (pos),
    .done_o  (done)
  );

  lbl_field_cap #(.ET1_END(ET1_END), .W1_END(W1_END), .CNT_W(CNT_W)) u_cap (
    .clk_i, .rst_ni,
    .beat_i(beat),
    .data_i(s_tdata_i),
    .pos_i (pos),
    .word_o(word),
    .w1_o  (w1),
    .fine_o(fine)
  );

  lbl_decide #(
    .ET1_END(ET1_END), .W1_END(W1_END), .ET2_END(ET2_END), .W2_END(W2_END), .CNT_W(CNT_W)
  ) u_dec (
    .beat_i  (beat),
    .last_i  (s_tlast_i),
    .done_i  (done),
    .pos_i   (pos),
    .word_i  (word),
    .w1_i    (w1),
    .fine_i  (fine),
    .decide_o(decide),
    .res_o   (res_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ready_q <= 1'b0;
      vld_q   <= 1'b0;
      res_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      vld_q   <= decide;
      if (decide) res_q <= res_d;
    end
  end

  assign s_tready_o    = ready_q;
  assign res_valid_o   = vld_q;
  assign res_class_o   = res_q.cls;
  assign res_discard_o = res_q.discard;
  assign res_label_o   = res_q.label;
  assign res_tx_pcp_o  = res_q.tx_pcp;
  assign res_tx_dei_o  = res_q.tx_dei;
  assign res_org_pcp_o = res_q.org_pcp;
  assign res_org_dei_o = res_q.org_dei;

  a_r11_discard_clears_fields: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_discard_o) |-> (res_label_o == '0 && res_tx_pcp_o == '0 &&
      !res_tx_dei_o && res_org_pcp_o == '0 && !res_org_dei_o));

  a_r3_vlan_label_narrow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_class_o == CLS_VLAN) |->
      (res_label_o[23:12] == '0 && res_tx_pcp_o == res_org_pcp_o && res_tx_dei_o == res_org_dei_o));

  a_r9_result_follows_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $past(beat));

  a_r1_no_result_before_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !s_tready_o |-> !res_valid_o);

  a_r4_fine_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && (res_class_o == CLS_FINE || res_class_o == CLS_VLAN)) |-> !res_discard_o);

endmodule

// File: tb/inner_label_parser_test.sv
module inner_label_parser_test;

  typedef struct packed {
    logic [15:0] et1;
    logic [15:0] w1;
    logic [15:0] et2;
    logic [15:0] w2;
    logic [7:0]  len;
    logic [7:0]  dpos;
    logic [1:0]  cls;
    logic        dis;
    logic [23:0] lbl;
    logic [2:0]  tp;
    logic        td;
    logic [2:0]  op;
    logic        od;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{16'h8100, 16'hA123, 16'h0000, 16'h0000, 8'd20, 8'd15, 2'd1, 1'b0, 24'h000123, 3'd5, 1'b0, 3'd5, 1'b0},
    '{16'h893B, 16'h7ABC, 16'h893B, 16'h2DEF, 8'd24, 8'd19, 2'd2, 1'b0, 24'hABCDEF, 3'd3, 1'b1, 3'd1, 1'b0},
    '{16'h893B, 16'h7ABC, 16'h8100, 16'h2DEF, 8'd24, 8'd17, 2'd3, 1'b1, 24'h000000, 3'd0, 1'b0, 3'd0, 1'b0},
    '{16'h0800, 16'hA123, 16'h893B, 16'h2DEF, 8'd30, 8'd13, 2'd0, 1'b1, 24'h000000, 3'd0, 1'b0, 3'd0, 1'b0},
    '{16'h8100, 16'hA123, 16'h0000, 16'h0000, 8'd14, 8'd13, 2'd3, 1'b1, 24'h000000, 3'd0, 1'b0, 3'd0, 1'b0},
    '{16'h893B, 16'h7ABC, 16'h893B, 16'h2DEF, 8'd19, 8'd18, 2'd3, 1'b1, 24'h000000, 3'd0, 1'b0, 3'd0, 1'b0},
    '{16'h893B, 16'hF001, 16'h893B, 16'h0FFE, 8'd20, 8'd19, 2'd2, 1'b0, 24'h001FFE, 3'd7, 1'b1, 3'd0, 1'b0},
    '{16'h8100, 16'h1FFF, 16'h0000, 16'h0000, 8'd16, 8'd15, 2'd1, 1'b0, 24'h000FFF, 3'd0, 1'b1, 3'd0, 1'b1},
    '{16'h893B, 16'h7ABC, 16'h893B, 16'h2DEF, 8'd5,  8'd4,  2'd3, 1'b1, 24'h000000, 3'd0, 1'b0, 3'd0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tlast = 1'b0;
  logic        s_tready;
  logic        res_valid;
  logic [1:0]  res_class;
  logic        res_discard;
  logic [23:0] res_label;
  logic [2:0]  res_tx_pcp, res_org_pcp;
  logic        res_tx_dei, res_org_dei;

  int total = 0;
  int failed = 0;
  int cyc = 0;
  int n_res = 0;
  int res_cyc = 0;
  int dec_cyc = 0;
  logic [1:0]  c_cls;
  logic        c_dis;
  logic [23:0] c_lbl;
  logic [2:0]  c_tp, c_op;
  logic        c_td, c_od;

  always #4 clk = ~clk;

  inner_label_parser uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .s_tdata_i(s_tdata), .s_tvalid_i(s_tvalid), .s_tlast_i(s_tlast), .s_tready_o(s_tready),
    .res_valid_o(res_valid), .res_class_o(res_class), .res_discard_o(res_discard),
    .res_label_o(res_label), .res_tx_pcp_o(res_tx_pcp), .res_tx_dei_o(res_tx_dei),
    .res_org_pcp_o(res_org_pcp), .res_org_dei_o(res_org_dei)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (res_valid) begin
      n_res   <= n_res + 1;
      res_cyc <= cyc;
      c_cls <= res_class; c_dis <= res_discard; c_lbl <= res_label;
      c_tp <= res_tx_pcp; c_td <= res_tx_dei; c_op <= res_org_pcp; c_od <= res_org_dei;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  endtask

  function automatic logic [7:0] byte_at(input vec_t v, input int i);
    if (i < 12)       return (i % 2 == 0) ? 8'h81 : 8'h00;   // fake tags inside MACs (R2)
    else if (i == 12) return v.et1[15:8];
    else if (i == 13) return v.et1[7:0];
    else if (i == 14) return v.w1[15:8];
    else if (i == 15) return v.w1[7:0];
    else if (i == 16) return v.et2[15:8];
    else if (i == 17) return v.et2[7:0];
    else if (i == 18) return v.w2[15:8];
    else if (i == 19) return v.w2[7:0];
    else              return (i % 2 == 0) ? 8'h89 : 8'h3B;
  endfunction

  task automatic send(input vec_t v, input int gap);
    for (int i = 0; i < int'(v.len); i++) begin
      @(negedge clk);
      s_tvalid = 1'b1;
      s_tdata  = byte_at(v, i);
      s_tlast  = (i == int'(v.len) - 1);
      @(posedge clk);
      #1;
      if (i == int'(v.dpos)) dec_cyc = cyc;
      if (gap > 0) begin
        @(negedge clk);
        s_tvalid = 1'b0;
        s_tdata  = 8'h81;
        repeat (gap - 1) @(negedge clk);
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
  endtask

  task automatic run_vec(input int k, input int gap);
    vec_t v;
    v = VECS[k];
    @(negedge clk);
    n_res = 0;
    send(v, gap);
    repeat (2) @(negedge clk);
    chk(n_res == 1, "R9", "result count", n_res, 1);
    chk(res_cyc == dec_cyc, "R9", "result cycle", res_cyc, dec_cyc);
    chk(c_cls == v.cls, (v.cls == 2'd0) ? "R7" : (v.cls == 2'd3) ? "R8/R6" : "R3/R4", "class", c_cls, v.cls);
    chk(c_dis == v.dis, "R6", "discard", c_dis, v.dis);
    chk(c_lbl == v.lbl, v.dis ? "R11" : "R4", "label", c_lbl, v.lbl);
    chk({c_tp, c_td} == {v.tp, v.td}, "R5", "transport pcp/dei", {c_tp, c_td}, {v.tp, v.td});
    chk({c_op, c_od} == {v.op, v.od}, "R5", "original pcp/dei", {c_op, c_od}, {v.op, v.od});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    total++;
    failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(s_tready == 1'b0, "R1", "tready in reset", s_tready, 0);
    chk(res_valid == 1'b0, "R1", "valid in reset", res_valid, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(s_tready == 1'b1, "R1", "tready after reset", s_tready, 1);
    chk(res_valid == 1'b0, "R1", "valid after reset", res_valid, 0);

    // table walk, no gaps (R2..R9, R11)
    for (int k = 0; k < NV; k++) run_vec(k, 0);
    // same table with idle cycles between bytes (R10)
    for (int k = 0; k < NV; k++) run_vec(k, 2);

    // R10: stalled cycles produce no result
    n_res = 0;
    s_tvalid = 1'b0;
    s_tlast  = 1'b1;
    repeat (5) @(negedge clk);
    s_tlast  = 1'b0;
    chk(n_res == 0, "R10", "no result while idle", n_res, 0);

    // R10: back-to-back packets without an idle cycle
    n_res = 0;
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        s_tvalid = 1'b1;
        s_tdata  = byte_at(VECS[7], i);
        s_tlast  = (i == 15);
      end
    end
    @(negedge clk);
    s_tvalid = 1'b0;
    s_tlast  = 1'b0;
    repeat (2) @(negedge clk);
    chk(n_res == 2, "R10", "back-to-back results", n_res, 2);
    chk(c_lbl == 24'h000FFF, "R10", "second packet label", c_lbl, 24'h000FFF);

    summary();
  end

endmodule